// File: doc/BRIEF.md
# Machine-Mode Control Register File with Write Legalization

This block holds the 64-bit control and status registers of a small core. It also gives a privilege-gated view of counters that are kept outside the block. The pipeline presents a register index with a read strobe or a write strobe, the current privilege level and the low bits of the next program counter. Read data comes back in the same cycle. A write is committed at the next rising clock edge.

On write, each special register applies a fixed legalization rule:
- The address-translation register accepts only two mode encodings.
- The trigger-select register stores one more than the value written.
- The feature register refuses to drop compressed-instruction support while the next PC is not word aligned.
- The status register never lets its two width fields change.

Reads of the two saved exception PCs are masked according to the compressed-instruction bit. An index past the implemented range raises an illegal flag and touches nothing.

Index map:
- 0 to 31: counters. 0 is cycle, 1 is wall time, 2 is retired instructions, and 3 to 31 all return the cycle count.
- 32: feature register.
- 33: status.
- 34: machine counter enable.
- 35: supervisor counter enable.
- 36: trigger select.
- 37: machine exception PC.
- 38: supervisor exception PC.
- 39: translation register.
- 40 to 40+NUM_PLAIN-1: plain storage registers.

Top module: `csr_mfile`

## Requirements
- R1: After reset, every register reads zero, with these exceptions:
  - The feature register (index 32) reads 64'h8000_0000_0014_112D: width field [63:62]=2, and its compressed bit is bit 2.
  - Status (index 33) reads 64'h0000_000A_0000_2000: field [35:34]=2, field [33:32]=2 and field [14:13]=1.
  - Both counter enables (indices 34 and 35) read 7.
  - Trigger select (index 36) reads 1.
- R2: In machine privilege (priv=2'b11), every counter read is allowed. Index 0 returns cycle_cnt, index 1 returns time_cnt, index 2 returns retired_cnt, and indices 3 to 31 return cycle_cnt.
- R3: In supervisor privilege (priv=2'b01), counter index n is readable only when bit n of the machine counter enable is set. At any other privilege, bit n of the supervisor counter enable must be set. A denied counter reads zero.
- R4: Writes to indices 0 to 31 change no state.
- R5: A read of index 37 or 38 returns the stored value with bits [1:0] cleared when the compressed bit is 0, and with only bit 0 cleared when it is 1.
- R6: A write to index 39 whose mode field [63:60] is neither 0 nor 8 keeps the previous mode and still stores bits [59:0].
- R7: A write to index 36 stores the written value plus one, modulo 2^64.
- R8: A write to index 32 with bit 2 clear keeps the old bit 2 when next_pc_lo is nonzero. All other bits are written as given.
- R9: A write to index 33 never changes bits [35:32].
- R10: An index above 40+NUM_PLAIN-1 with rd_en or wr_en high raises illegal in that same cycle, returns zero and changes no state.
- R11: Reads are combinational and return zero while rd_en is low. A write becomes visible in the cycle after its clock edge. Plain registers store the written data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx | input | IDX_W | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 64 | Write data |
| priv | input | 2 | Privilege: 3 machine, 1 supervisor, else user |
| next_pc_lo | input | 3 | Bits [2:0] of the next program counter |
| cycle_cnt | input | 64 | External cycle count |
| time_cnt | input | 64 | External wall-time count |
| retired_cnt | input | 64 | External retired-instruction count |
| rd_data | output | 64 | Read data |
| illegal | output | 1 | Index out of range |

## Verification
A wrong internal register shows up at rd_data on the first read of that index after the faulty write edge. For a legalized field, the error is visible one cycle after the write. A wrong compressed bit is seen indirectly as well, because it changes the exception-PC masks on the very next read. A wrong enable register shows as a counter that reads zero, or one that leaks, when a lower privilege reads it. An out-of-range write that corrupts state stays hidden until a legal register is read back.

// File: rtl/csr_mfile_pkg.sv
package csr_mfile_pkg;
    localparam int XW        = 64;
    localparam int CNT_SLOTS = 32;

    localparam int IX_FEAT   = 32;
    localparam int IX_STAT   = 33;
    localparam int IX_MCEN   = 34;
    localparam int IX_SCEN   = 35;
    localparam int IX_TSEL   = 36;
    localparam int IX_MEPC   = 37;
    localparam int IX_SEPC   = 38;
    localparam int IX_XLAT   = 39;
    localparam int IX_PLAIN0 = 40;

    localparam int FEAT_C_BIT   = 2;
    localparam int XLAT_MODE_LO = 60;

    localparam logic [1:0] PRIV_MACH  = 2'b11;
    localparam logic [1:0] PRIV_SUPER = 2'b01;

    localparam logic [3:0] MODE_OFF  = 4'd0;
    localparam logic [3:0] MODE_PG39 = 4'd8;

    localparam logic [XW-1:0] STAT_LOCK_MASK = 64'h0000_000F_0000_0000;
    localparam logic [XW-1:0] FEAT_RST       = 64'h8000_0000_0014_112D;
    localparam logic [XW-1:0] STAT_RST       = 64'h0000_000A_0000_2000;
    localparam logic [XW-1:0] CEN_RST        = 64'h7;
    localparam logic [XW-1:0] TSEL_RST       = 64'h1;
endpackage

// File: rtl/csr_cnt_view.sv
module csr_cnt_view
    import csr_mfile_pkg::*;
#(
    parameter int SLOTS = CNT_SLOTS,
    parameter int CW    = XW
) (
    input  logic [$clog2(SLOTS)-1:0] slot,
    input  logic [1:0]               priv,
    input  logic [SLOTS-1:0]         m_en,
    input  logic [SLOTS-1:0]         s_en,
    input  logic [CW-1:0]            cyc,
    input  logic [CW-1:0]            tim,
    input  logic [CW-1:0]            ret,
    output logic [CW-1:0]            value
);
    logic [SLOTS-1:0][CW-1:0] src;
    logic                     allow;

    for (genvar g = 0; g < SLOTS; g++) begin : g_src
        if (g == 1) begin : g_time
            assign src[g] = tim;
        end else if (g == 2) begin : g_ret
            assign src[g] = ret;
        end else begin : g_cyc
            assign src[g] = cyc;
        end
    end

    always_comb begin
        case (priv)
            PRIV_MACH:  allow = 1'b1;
            PRIV_SUPER: allow = m_en[slot];
            default:    allow = s_en[slot];
        endcase
        value = allow ? src[slot] : '0;
    end
endmodule

// File: rtl/csr_wr_legal.sv
module csr_wr_legal
    import csr_mfile_pkg::*;
(
    input  logic [XW-1:0] wdata,
    input  logic [XW-1:0] cur_feat,
    input  logic [XW-1:0] cur_stat,
    input  logic [XW-1:0] cur_xlat,
    input  logic [2:0]    next_pc_lo,
    output logic [XW-1:0] feat_new,
    output logic [XW-1:0] stat_new,
    output logic [XW-1:0] tsel_new,
    output logic [XW-1:0] xlat_new
);
    logic [3:0] mode_w;

    always_comb begin
        feat_new = wdata;
        if (!wdata[FEAT_C_BIT] && (next_pc_lo != 3'b000)) begin
            feat_new[FEAT_C_BIT] = cur_feat[FEAT_C_BIT];
        end

        stat_new = (wdata & ~STAT_LOCK_MASK) | (cur_stat & STAT_LOCK_MASK);

        tsel_new = wdata + 64'd1;

        mode_w   = wdata[XLAT_MODE_LO +: 4];
        xlat_new = wdata;
        if ((mode_w != MODE_OFF) && (mode_w != MODE_PG39)) begin
            xlat_new[XLAT_MODE_LO +: 4] = cur_xlat[XLAT_MODE_LO +: 4];
        end
    end
endmodule

// File: rtl/csr_mfile.sv
module csr_mfile
    import csr_mfile_pkg::*;
#(
    parameter int NUM_PLAIN = 8,
    parameter int IDX_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [XW-1:0]    wdata,
    input  logic [1:0]       priv,
    input  logic [2:0]       next_pc_lo,
    input  logic [XW-1:0]    cycle_cnt,
    input  logic [XW-1:0]    time_cnt,
    input  logic [XW-1:0]    retired_cnt,
    output logic [XW-1:0]    rd_data,
    output logic             illegal
);
    localparam int LAST_IDX = IX_PLAIN0 + NUM_PLAIN - 1;
    localparam int SLOT_W   = $clog2(CNT_SLOTS);

    typedef struct packed {
        logic [XW-1:0]                feat;
        logic [XW-1:0]                stat;
        logic [XW-1:0]                mcen;
        logic [XW-1:0]                scen;
        logic [XW-1:0]                tsel;
        logic [XW-1:0]                mepc;
        logic [XW-1:0]                sepc;
        logic [XW-1:0]                xlat;
        logic [NUM_PLAIN-1:0][XW-1:0] plain;
    } state_t;

    state_t st_d, st_q;

    logic          idx_ok;
    logic [XW-1:0] cnt_val;
    logic [XW-1:0] feat_new, stat_new, tsel_new, xlat_new;
    logic [XW-1:0] epc_mask;
    logic [XW-1:0] rd_val;
    logic [XW-1:0] cur_tsel, cur_xlat, cur_stat;
    logic [CNT_SLOTS-1:0] cur_scen;

    assign cur_tsel = st_q.tsel;
    assign cur_xlat = st_q.xlat;
    assign cur_stat = st_q.stat;
    assign cur_scen = st_q.scen[CNT_SLOTS-1:0];

    assign idx_ok  = (int'(idx) <= LAST_IDX);
    assign illegal = (rd_en || wr_en) && !idx_ok;

    csr_cnt_view #(.SLOTS(CNT_SLOTS), .CW(XW)) u_cnt (
        .slot  (idx[SLOT_W-1:0]),
        .priv  (priv),
        .m_en  (st_q.mcen[CNT_SLOTS-1:0]),
        .s_en  (st_q.scen[CNT_SLOTS-1:0]),
        .cyc   (cycle_cnt),
        .tim   (time_cnt),
        .ret   (retired_cnt),
        .value (cnt_val)
    );

    csr_wr_legal u_legal (
        .wdata      (wdata),
        .cur_feat   (st_q.feat),
        .cur_stat   (st_q.stat),
        .cur_xlat   (st_q.xlat),
        .next_pc_lo (next_pc_lo),
        .feat_new   (feat_new),
        .stat_new   (stat_new),
        .tsel_new   (tsel_new),
        .xlat_new   (xlat_new)
    );

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_en && idx_ok) begin
            case (int'(idx))
                IX_FEAT: st_d.feat = feat_new;
                IX_STAT: st_d.stat = stat_new;
                IX_MCEN: st_d.mcen = wdata;
                IX_SCEN: st_d.scen = wdata;
                IX_TSEL: st_d.tsel = tsel_new;
                IX_MEPC: st_d.mepc = wdata;
                IX_SEPC: st_d.sepc = wdata;
                IX_XLAT: st_d.xlat = xlat_new;
                default: begin
                    for (int k = 0; k < NUM_PLAIN; k++) begin
                        if (int'(idx) == IX_PLAIN0 + k) st_d.plain[k] = wdata;
                    end
                end
            endcase
        end
    end

    // read path
    always_comb begin
        epc_mask = st_q.feat[FEAT_C_BIT] ? ~64'h1 : ~64'h3;
        rd_val   = '0;
        if (int'(idx) < CNT_SLOTS) begin
            rd_val = cnt_val;
        end else begin
            case (int'(idx))
                IX_FEAT: rd_val = st_q.feat;
                IX_STAT: rd_val = st_q.stat;
                IX_MCEN: rd_val = st_q.mcen;
                IX_SCEN: rd_val = st_q.scen;
                IX_TSEL: rd_val = st_q.tsel;
                IX_MEPC: rd_val = st_q.mepc & epc_mask;
                IX_SEPC: rd_val = st_q.sepc & epc_mask;
                IX_XLAT: rd_val = st_q.xlat;
                default: begin
                    for (int k = 0; k < NUM_PLAIN; k++) begin
                        if (int'(idx) == IX_PLAIN0 + k) rd_val = st_q.plain[k];
                    end
                end
            endcase
        end
        rd_data = (rd_en && idx_ok) ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.feat <= FEAT_RST;
            st_q.stat <= STAT_RST;
            st_q.mcen <= CEN_RST;
            st_q.scen <= CEN_RST;
            st_q.tsel <= TSEL_RST;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/csr_mfile_chk.sv
module csr_mfile_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] idx,
    input logic             rd_en,
    input logic             wr_en,
    input logic [63:0]      wdata,
    input logic [1:0]       priv,
    input logic [63:0]      rd_data,
    input logic             illegal,
    input logic [63:0]      cur_tsel,
    input logic [63:0]      cur_xlat,
    input logic [63:0]      cur_stat,
    input logic [31:0]      cur_scen
);
    // R10
    illegal_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> rd_data == 64'd0);

    // R9
    stat_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_stat[35:32] == 4'hA);

    // R6
    xlat_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_xlat[63:60] == 4'd0) || (cur_xlat[63:60] == 4'd8));

    // R7
    tsel_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(idx) == 36) |=> cur_tsel == $past(wdata) + 64'd1);

    // R5
    epc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(idx) == 37 || int'(idx) == 38)) |-> rd_data[0] == 1'b0);

    // R3
    cnt_user_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(idx) < 32 && priv == 2'b00 && !cur_scen[idx[4:0]])
            |-> rd_data == 64'd0);

    // R11
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == 64'd0);
endmodule

bind csr_mfile csr_mfile_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (idx),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .priv     (priv),
    .rd_data  (rd_data),
    .illegal  (illegal),
    .cur_tsel (cur_tsel),
    .cur_xlat (cur_xlat),
    .cur_stat (cur_stat),
    .cur_scen (cur_scen)
);

// File: tb/csr_mfile_tb.sv
module csr_mfile_tb;
    localparam logic [63:0] CYC = 64'h0000_0000_0000_1111;
    localparam logic [63:0] TIM = 64'h0000_0000_0022_2222;
    localparam logic [63:0] RET = 64'h0000_0003_3333_3333;
    localparam logic [63:0] FEAT_R = 64'h8000_0000_0014_112D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  idx = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [63:0] wdata = '0;
    logic [1:0]  priv = 2'b11;
    logic [2:0]  next_pc_lo = 3'b000;
    logic [63:0] rd_data;
    logic        illegal;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    csr_mfile u_dut (
        .clk(clk), .rst_n(rst_n), .idx(idx), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .priv(priv), .next_pc_lo(next_pc_lo),
        .cycle_cnt(CYC), .time_cnt(TIM), .retired_cnt(RET),
        .rd_data(rd_data), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int i, input logic [63:0] d, output logic ill);
        @(negedge clk);
        idx = 7'(i); wdata = d; wr_en = 1'b1;
        #1 ill = illegal;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int i, output logic [63:0] v, output logic ill);
        @(negedge clk);
        idx = 7'(i); rd_en = 1'b1;
        #1 v = rd_data; ill = illegal;
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] v; logic il;
        rd(32, v, il); chk("R1 feat", v, FEAT_R);
        rd(33, v, il); chk("R1 stat", v, 64'h0000_000A_0000_2000);
        rd(34, v, il); chk("R1 mcen", v, 64'h7);
        rd(35, v, il); chk("R1 scen", v, 64'h7);
        rd(36, v, il); chk("R1 tsel", v, 64'h1);
        rd(39, v, il); chk("R1 xlat", v, 64'h0);
        rd(37, v, il); chk("R1 mepc", v, 64'h0);
        rd(47, v, il); chk("R1 plain7", v, 64'h0);
    endtask

    task automatic t_discard;
        logic [63:0] v; logic il;
        wr(3, '1, il); wr(0, '1, il); wr(31, '1, il);
        rd(34, v, il); chk("R4 mcen kept", v, 64'h7);
        rd(35, v, il); chk("R4 scen kept", v, 64'h7);
        rd(36, v, il); chk("R4 tsel kept", v, 64'h1);
        rd(32, v, il); chk("R4 feat kept", v, FEAT_R);
        rd(0, v, il);  chk("R4 cycle view", v, CYC);
    endtask

    task automatic t_illegal;
        logic [63:0] v; logic il;
        wr(100, '1, il); chk("R10 wr flag", {63'd0, il}, 64'd1);
        wr(48, '1, il);  chk("R10 wr flag edge", {63'd0, il}, 64'd1);
        rd(100, v, il);  chk("R10 rd flag", {63'd0, il}, 64'd1);
        chk("R10 rd zero", v, 64'd0);
        rd(47, v, il);   chk("R10 plain7 kept", v, 64'd0);
        chk("R10 legal flag low", {63'd0, il}, 64'd0);
        rd(40, v, il);   chk("R10 plain0 kept", v, 64'd0);
        rd(34, v, il);   chk("R10 mcen kept", v, 64'h7);
    endtask

    task automatic t_plain;
        logic [63:0] v; logic il;
        wr(43, 64'hDEAD_BEEF_0123_4567, il);
        rd(43, v, il); chk("R11 plain3", v, 64'hDEAD_BEEF_0123_4567);
        @(negedge clk); idx = 7'd43; rd_en = 1'b0;
        #1 chk("R11 idle zero", rd_data, 64'd0);
    endtask

    task automatic t_counters;
        logic [63:0] v; logic il;
        priv = 2'b11;
        rd(0, v, il); chk("R2 cycle", v, CYC);
        rd(1, v, il); chk("R2 time", v, TIM);
        rd(2, v, il); chk("R2 retired", v, RET);
        rd(7, v, il); chk("R2 hpm7", v, CYC);
        rd(31, v, il); chk("R2 hpm31", v, CYC);
        wr(34, 64'h5, il); wr(35, 64'h2, il);
        priv = 2'b01;
        rd(0, v, il); chk("R3 sup cycle", v, CYC);
        rd(1, v, il); chk("R3 sup time denied", v, 64'd0);
        rd(2, v, il); chk("R3 sup retired", v, RET);
        priv = 2'b00;
        rd(1, v, il); chk("R3 usr time", v, TIM);
        rd(0, v, il); chk("R3 usr cycle denied", v, 64'd0);
        priv = 2'b11;
    endtask

    task automatic t_feat_epc;
        logic [63:0] v; logic il;
        wr(37, 64'h0FFF, il); wr(38, 64'h0F0F, il);
        rd(37, v, il); chk("R5 mepc c on", v, 64'h0FFE);
        next_pc_lo = 3'd6;
        wr(32, FEAT_R & ~64'h4, il);
        rd(32, v, il); chk("R8 c kept", v, FEAT_R);
        next_pc_lo = 3'd0;
        wr(32, (FEAT_R & ~64'h4) | 64'h40, il);
        rd(32, v, il); chk("R8 c cleared", v, (FEAT_R & ~64'h4) | 64'h40);
        rd(37, v, il); chk("R5 mepc c off", v, 64'h0FFC);
        rd(38, v, il); chk("R5 sepc c off", v, 64'h0F0C);
        wr(32, FEAT_R, il);
        rd(38, v, il); chk("R5 sepc c on", v, 64'h0F0E);
    endtask

    task automatic t_status;
        logic [63:0] v; logic il;
        wr(33, '1, il);
        rd(33, v, il); chk("R9 ones", v, 64'hFFFF_FFFA_FFFF_FFFF);
        wr(33, 64'd0, il);
        rd(33, v, il); chk("R9 zeros", v, 64'h0000_000A_0000_0000);
    endtask

    task automatic t_xlat;
        logic [63:0] v; logic il;
        wr(39, 64'h8000_0000_0000_1234, il);
        rd(39, v, il); chk("R6 pg39", v, 64'h8000_0000_0000_1234);
        wr(39, 64'h5000_0000_0000_0ABC, il);
        rd(39, v, il); chk("R6 bad mode", v, 64'h8000_0000_0000_0ABC);
        wr(39, 64'h0000_0000_0000_0077, il);
        rd(39, v, il); chk("R6 off", v, 64'h0000_0000_0000_0077);
    endtask

    task automatic t_tsel;
        logic [63:0] v; logic il;
        wr(36, 64'd5, il);
        rd(36, v, il); chk("R7 plus one", v, 64'd6);
        wr(36, '1, il);
        rd(36, v, il); chk("R7 wrap", v, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_discard();
        t_illegal();
        t_plain();
        t_counters();
        t_feat_epc();
        t_status();
        t_xlat();
        t_tsel();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule